// File: doc/BRIEF.md
# PHY Management Serial Controller

This block lets a host reach the management registers of an Ethernet PHY over the two-wire clock/data management bus (clause 22 framing). The host sees two 32-bit registers. One is a command word that holds the clock divider setting, the PHY and register addresses, and two request bits. The other is a data word: its low half carries the value to be written and its high half returns the value that was read. Setting a request bit in the command word starts one complete frame on the management pins. The request bit stays set until the last bit of the frame has been clocked out, so the host can poll it to tell when the controller is busy.

The management clock is made from the system clock. A counter runs while a frame is in progress and inverts the clock each time it reaches the programmed divider value, so one management clock period lasts twice that value in system cycles. Each frame has a 32-bit preamble of ones, the start code, the operation code, both addresses, the turnaround and 16 data bits. On a read the controller releases the data line from the turnaround onward and samples it as the management clock rises. The 16 sampled bits are stored when the frame ends.

Top module: `phy_mgmt_ctrl`

## Requirements
- R1: After reset the command word and the data word both read 0x00000000, `mdc` is low and `mdio_oe` is low.
- R2: When a frame ends, the controller clears only the request bit. The divider field (command bits [5:0]), PHY address (bits [20:16]) and register address (bits [25:21]) read back exactly as the host wrote them, and all other command bits read 0.
- R3: With divider value D (D=0 is taken as 1), `mdc` stays low while idle. It first rises D cycles after the clock edge that accepted the request, then has a period of 2·D cycles. The request bit clears 128·D cycles after that edge.
- R4: The bits on `mdio_o`, one per rising edge of `mdc`, are 32 ones, then 0 1, then the operation (1 0 for read, 0 1 for write), then the 5-bit PHY address and the 5-bit register address, each most significant bit first. A frame has exactly 64 rising edges of `mdc`.
- R5: For a write (command bit 27), `mdio_oe` stays high for all 64 bits. Turnaround is 1 0, followed by data word bits [15:0], most significant bit first. The data is captured at the edge that accepts the request, so a later write to the data word does not change the frame.
- R6: For a read (command bit 26), `mdio_oe` is high for the first 46 bits and low for the last 18. `mdio_i` is sampled on the last 16 rising edges of `mdc`, first sample as the most significant bit. The result appears in data word bits [31:16] when the request bit clears.
- R7: A read during which `mdio_i` stays high (no PHY answering) returns 0xFFFF in data word bits [31:16].
- R8: A command word write while a request bit is set is ignored completely. The fields keep their values, the running frame keeps its timing and content, and no second frame follows.
- R9: A command write with both bit 26 and bit 27 set starts a read. Only bit 26 reads back as set.
- R10: A host write to the data word changes only bits [15:0]. Bits [31:16] change only when a read frame completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Host write strobe, one cycle per write |
| reg_sel | input | 1 | Write target: 0 command word, 1 data word |
| reg_wdata | input | 32 | Host write value |
| reg_rsel | input | 1 | Read select: 0 command word, 1 data word |
| reg_rdata | output | 32 | Selected register value (combinational) |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Management data driven toward the PHY |
| mdio_oe | output | 1 | High while the controller drives the data line |
| mdio_i | input | 1 | Management data sampled from the line |

## Verification
All timing is counted from the system clock edge that accepts the command write. The first `mdc` rise is due D cycles later and each following rise 2·D cycles after the one before. The request bit and the read result both change on the edge 128·D cycles after the accepting edge. The bench reads the command word at the falling edge just before that edge and again at the falling edge just after it, so both the still-busy and the finished state are checked at the exact cycle. Frame bits are captured on each `mdc` rise, and read responses are driven on each `mdc` fall, so no sample falls on an edge where the sampled line changes.

// File: rtl/phy_mgmt_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the PHY management controller.
// Field positions are the ones the host software decodes; the frame
// codes are fixed by the clause 22 management frame.
package phy_mgmt_pkg;
    localparam int PHY_AW    = 5;   // PHY and register address width
    localparam int MII_DW    = 16;  // management data width
    localparam int PHY_LSB   = 16;  // command word: PHY address low bit
    localparam int REG_LSB   = 21;  // command word: register address low bit
    localparam int RD_BIT    = 26;  // command word: read request
    localparam int WR_BIT    = 27;  // command word: write request
    localparam int RDATA_LSB = 16;  // data word: read result low bit

    localparam logic [1:0] ST_CODE = 2'b01;
    localparam logic [1:0] OP_RD   = 2'b10;
    localparam logic [1:0] OP_WR   = 2'b01;
    localparam logic [1:0] TA_WR   = 2'b10;

    typedef enum logic {SEL_CTRL = 1'b0, SEL_DATA = 1'b1} reg_sel_e;

    typedef struct packed {
        logic              is_read;
        logic [PHY_AW-1:0] phy;
        logic [PHY_AW-1:0] regad;
        logic [MII_DW-1:0] wdata;
    } mgmt_cmd_t;
endpackage

// File: rtl/mgmt_regs.sv
`timescale 1ns/1ps
// Host-visible command and data words.
// Accepts a command write only while idle, issues a one-cycle start
// with the command captured (write data taken from the data word at
// that edge), clears the request bit on frame completion and stores
// the read result. Assumes THR_W <= 16 so the divider field fits below
// the PHY address field.
module mgmt_regs
    import phy_mgmt_pkg::*;
#(
    parameter int THR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_sel,
    input  logic [31:0]       reg_wdata,
    input  logic              reg_rsel,
    output logic [31:0]       reg_rdata,
    input  logic              done,
    input  logic [MII_DW-1:0] rd_capture,
    output logic              start,
    output mgmt_cmd_t         cmd,
    output logic [THR_W-1:0]  cfg_thr,
    output logic              rd_req,
    output logic              wr_req
);
    logic [THR_W-1:0]  thr_q;
    logic [PHY_AW-1:0] phy_q;
    logic [PHY_AW-1:0] reg_q;
    logic              rd_q;
    logic              wr_q;
    logic [MII_DW-1:0] wdata_q;
    logic [MII_DW-1:0] rdata_q;
    logic              busy;
    logic              accept;
    logic              data_wr;
    logic [31:0]       ctrl_word;
    logic [31:0]       data_word;
    logic              unused_hi;

    assign unused_hi = ^reg_wdata[31:28];

    // Decode the host strobe into command acceptance and start.
    always_comb begin
        busy    = rd_q | wr_q;
        accept  = reg_wr && (reg_sel == SEL_CTRL) && !busy;
        data_wr = reg_wr && (reg_sel == SEL_DATA);
        start   = accept && (reg_wdata[RD_BIT] || reg_wdata[WR_BIT]);
        cmd.is_read = reg_wdata[RD_BIT];
        cmd.phy     = reg_wdata[PHY_LSB +: PHY_AW];
        cmd.regad   = reg_wdata[REG_LSB +: PHY_AW];
        cmd.wdata   = wdata_q;
    end

    // Hold the command fields, request bits and data halves.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thr_q   <= '0;
            phy_q   <= '0;
            reg_q   <= '0;
            rd_q    <= 1'b0;
            wr_q    <= 1'b0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            if (accept) begin
                thr_q <= reg_wdata[THR_W-1:0];
                phy_q <= reg_wdata[PHY_LSB +: PHY_AW];
                reg_q <= reg_wdata[REG_LSB +: PHY_AW];
                rd_q  <= reg_wdata[RD_BIT];
                wr_q  <= reg_wdata[WR_BIT] && !reg_wdata[RD_BIT];
            end else if (done) begin
                rd_q <= 1'b0;
                wr_q <= 1'b0;
            end
            if (done && rd_q) begin
                rdata_q <= rd_capture;
            end
            if (data_wr) begin
                wdata_q <= reg_wdata[MII_DW-1:0];
            end
        end
    end

    // Assemble the two read-back words and select one.
    always_comb begin
        ctrl_word = '0;
        ctrl_word[THR_W-1:0]            = thr_q;
        ctrl_word[PHY_LSB +: PHY_AW]    = phy_q;
        ctrl_word[REG_LSB +: PHY_AW]    = reg_q;
        ctrl_word[RD_BIT]               = rd_q;
        ctrl_word[WR_BIT]               = wr_q;
        data_word = '0;
        data_word[MII_DW-1:0]           = wdata_q;
        data_word[RDATA_LSB +: MII_DW]  = rdata_q;
        reg_rdata = (reg_rsel == SEL_DATA) ? data_word : ctrl_word;
    end

    assign cfg_thr = thr_q;
    assign rd_req  = rd_q;
    assign wr_req  = wr_q;
endmodule

// File: rtl/mdc_divider.sv
`timescale 1ns/1ps
// Management clock generator.
// While run is high a counter counts system cycles and inverts mdc each
// time it reaches the divider value (0 behaves as 1). rise and fall
// flag the cycle whose closing edge makes mdc go high or low. Idle
// state is mdc low with the counter cleared, so every frame starts in phase.
module mdc_divider #(
    parameter int THR_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [THR_W-1:0] thr,
    output logic             mdc,
    output logic             rise,
    output logic             fall
);
    logic [THR_W-1:0] cnt_q;
    logic [THR_W-1:0] thr_eff;
    logic             mdc_q;
    logic             hit;

    // Clamp the divider value and find the toggle cycle.
    always_comb begin
        thr_eff = (thr == '0) ? THR_W'(1) : thr;
        hit     = run && (cnt_q == thr_eff - THR_W'(1));
        rise    = hit && !mdc_q;
        fall    = hit && mdc_q;
    end

    // Count cycles and toggle the clock output.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
            mdc_q <= 1'b0;
        end else if (hit) begin
            cnt_q <= '0;
            mdc_q <= ~mdc_q;
        end else begin
            cnt_q <= cnt_q + THR_W'(1);
        end
    end

    assign mdc = mdc_q;
endmodule

// File: rtl/mdio_frame_seq.sv
`timescale 1ns/1ps
// Management frame sequencer.
// Loads the whole frame into a shift register on start, moves to the
// next bit on each mdc fall, and samples mdio_i on each mdc rise during
// the data field of a read. The data line is released from the
// turnaround onward on reads. Assumes start only arrives while idle.
module mdio_frame_seq
    import phy_mgmt_pkg::*;
#(
    parameter int PREAMBLE_LEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  mgmt_cmd_t         cmd,
    input  logic              rise,
    input  logic              fall,
    input  logic              mdio_i,
    output logic              run,
    output logic              done,
    output logic [$clog2(PREAMBLE_LEN+2*PHY_AW+MII_DW+6)-1:0] idx,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic [MII_DW-1:0] rd_capture
);
    localparam int FRAME_LEN = PREAMBLE_LEN + 2*PHY_AW + MII_DW + 6;
    localparam int IDX_W     = $clog2(FRAME_LEN);
    localparam int TA_IDX    = PREAMBLE_LEN + 4 + 2*PHY_AW;
    localparam int DATA_IDX  = TA_IDX + 2;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);

    logic                 run_q;
    logic                 rd_q;
    logic [IDX_W-1:0]     idx_q;
    logic [FRAME_LEN-1:0] frame_q;
    logic [MII_DW-1:0]    cap_q;
    logic [FRAME_LEN-1:0] frame_init;

    // Build the frame image from the captured command.
    always_comb begin
        frame_init = {{PREAMBLE_LEN{1'b1}}, ST_CODE,
                      (cmd.is_read ? OP_RD : OP_WR),
                      cmd.phy, cmd.regad, TA_WR,
                      (cmd.is_read ? {MII_DW{1'b0}} : cmd.wdata)};
    end

    // Step through the frame and collect read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q   <= 1'b0;
            rd_q    <= 1'b0;
            idx_q   <= '0;
            frame_q <= '0;
            cap_q   <= '0;
        end else if (start) begin
            run_q   <= 1'b1;
            rd_q    <= cmd.is_read;
            idx_q   <= '0;
            frame_q <= frame_init;
            cap_q   <= '0;
        end else if (run_q) begin
            if (rise && rd_q && (idx_q >= IDX_W'(DATA_IDX))) begin
                cap_q <= {cap_q[MII_DW-2:0], mdio_i};
            end
            if (fall) begin
                frame_q <= {frame_q[FRAME_LEN-2:0], 1'b0};
                idx_q   <= idx_q + IDX_W'(1);
                if (idx_q == LAST_IDX) begin
                    run_q <= 1'b0;
                end
            end
        end
    end

    // Drive the pins and flag the final bit.
    always_comb begin
        done    = run_q && fall && (idx_q == LAST_IDX);
        mdio_o  = run_q && frame_q[FRAME_LEN-1];
        mdio_oe = run_q && (!rd_q || (idx_q < IDX_W'(TA_IDX)));
    end

    assign run        = run_q;
    assign idx        = idx_q;
    assign rd_capture = cap_q;
endmodule

// File: rtl/phy_mgmt_ctrl.sv
`timescale 1ns/1ps
// PHY management controller top.
// Connects the host register words, the management clock divider and
// the frame sequencer. One frame runs per accepted request; the host
// polls the request bit for completion. The data line is split into
// output, enable and input for an external tri-state pad.
module phy_mgmt_ctrl
    import phy_mgmt_pkg::*;
#(
    parameter int THR_W        = 6,
    parameter int PREAMBLE_LEN = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_sel,
    input  logic [31:0] reg_wdata,
    input  logic        reg_rsel,
    output logic [31:0] reg_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    localparam int FRAME_LEN = PREAMBLE_LEN + 2*PHY_AW + MII_DW + 6;
    localparam int IDX_W     = $clog2(FRAME_LEN);
    localparam int TA_IDX    = PREAMBLE_LEN + 4 + 2*PHY_AW;

    logic              start;
    mgmt_cmd_t         cmd;
    logic [THR_W-1:0]  cfg_thr;
    logic              ctrl_rd_req;
    logic              ctrl_wr_req;
    logic              seq_run;
    logic              seq_done;
    logic [IDX_W-1:0]  seq_idx;
    logic [MII_DW-1:0] rd_capture;
    logic              mdc_rise;
    logic              mdc_fall;

    mgmt_regs #(.THR_W(THR_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .reg_rsel(reg_rsel), .reg_rdata(reg_rdata),
        .done(seq_done), .rd_capture(rd_capture),
        .start(start), .cmd(cmd), .cfg_thr(cfg_thr),
        .rd_req(ctrl_rd_req), .wr_req(ctrl_wr_req)
    );

    mdc_divider #(.THR_W(THR_W)) u_div (
        .clk(clk), .rst_n(rst_n), .run(seq_run), .thr(cfg_thr),
        .mdc(mdc), .rise(mdc_rise), .fall(mdc_fall)
    );

    mdio_frame_seq #(.PREAMBLE_LEN(PREAMBLE_LEN)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd),
        .rise(mdc_rise), .fall(mdc_fall), .mdio_i(mdio_i),
        .run(seq_run), .done(seq_done), .idx(seq_idx),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .rd_capture(rd_capture)
    );
endmodule

// File: rtl/phy_mgmt_ctrl_sva.sv
`timescale 1ns/1ps
// Protocol checker for the PHY management controller, bound to the top.
// Relates the register-side request bits to the divider and sequencer
// outputs.
module phy_mgmt_ctrl_sva #(
    parameter int THR_W  = 6,
    parameter int IDX_W  = 6,
    parameter int TA_IDX = 46
) (
    input logic             clk,
    input logic             rst_n,
    input logic             seq_run,
    input logic [IDX_W-1:0] seq_idx,
    input logic             mdc,
    input logic             mdio_oe,
    input logic             ctrl_rd_req,
    input logic             ctrl_wr_req,
    input logic [THR_W-1:0] cfg_thr
);
    // R3: clock held low whenever no frame runs
    assert_mdc_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !seq_run |-> !mdc);

    // R3: clock only moves while a frame ran in the previous cycle
    assert_mdc_moves_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mdc) |-> $past(seq_run));

    // R5: a write request keeps the line driven
    assert_write_drives_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr_req |-> mdio_oe);

    // R6: a read request releases the line from turnaround on
    assert_read_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_rd_req && (seq_idx >= IDX_W'(TA_IDX))) |-> !mdio_oe);

    // R9: at most one request bit set
    assert_one_request_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ctrl_rd_req, ctrl_wr_req}));

    // R8: divider setting frozen while busy
    assert_thr_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((ctrl_rd_req || ctrl_wr_req) && $past(ctrl_rd_req || ctrl_wr_req)) |-> $stable(cfg_thr));

    // R2: end of frame leaves no request pending
    assert_end_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(seq_run) |-> (!ctrl_rd_req && !ctrl_wr_req));
endmodule

bind phy_mgmt_ctrl phy_mgmt_ctrl_sva #(
    .THR_W(THR_W), .IDX_W(IDX_W), .TA_IDX(TA_IDX)
) u_sva (
    .clk(clk), .rst_n(rst_n), .seq_run(seq_run), .seq_idx(seq_idx),
    .mdc(mdc), .mdio_oe(mdio_oe), .ctrl_rd_req(ctrl_rd_req),
    .ctrl_wr_req(ctrl_wr_req), .cfg_thr(cfg_thr)
);

// File: tb/phy_mgmt_ctrl_test.sv
`timescale 1ns/1ps
// Self-checking bench: sweeps divider values and all PHY addresses,
// models a PHY answering reads, and checks timing and frame bits.
module phy_mgmt_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_sel = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic        reg_rsel = 1'b0;
    logic [31:0] reg_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int          n_checks = 0;
    int          n_fail = 0;
    int          rise_cnt = 0;
    logic [63:0] cap_o, cap_oe;
    logic [15:0] resp_q = '0;
    bit          phy_on = 1'b1;
    time         t_wr, t_first, t_second;

    phy_mgmt_ctrl uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rsel(reg_rsel), .reg_rdata(reg_rdata),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    always #10 clk = ~clk;

    // Capture frame bits on each management clock rise.
    always @(posedge mdc) begin
        if (rise_cnt == 0) t_first = $time;
        if (rise_cnt == 1) t_second = $time;
        if (rise_cnt < 64) begin
            cap_o[63-rise_cnt]  = mdio_o;
            cap_oe[63-rise_cnt] = mdio_oe;
        end
        rise_cnt = rise_cnt + 1;
    end

    // PHY model: present the next read bit after each fall.
    always @(negedge mdc) begin
        if (phy_on && rise_cnt >= 48 && rise_cnt < 64) mdio_i = resp_q[63-rise_cnt];
        else mdio_i = 1'b1;
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic host_write(input bit sel, input logic [31:0] val);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = val;
        @(posedge clk);
        t_wr = $time;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic host_read(input bit sel, output logic [31:0] val);
        reg_rsel = sel;
        #1;
        val = reg_rdata;
    endtask

    task automatic wait_to(input time t);
        while ($time < t) @(negedge clk);
    endtask

    function automatic logic [31:0] ctrl_word(input bit rd, input bit wr, input int ra, input int phy, input int thr);
        return {4'b0, wr, rd, ra[4:0], phy[4:0], 10'b0, thr[5:0]};
    endfunction

    function automatic logic [63:0] exp_frame(input bit rd, input int phy, input int ra, input logic [15:0] wd);
        return {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), phy[4:0], ra[4:0], 2'b10, (rd ? 16'h0 : wd)};
    endfunction

    // One complete command with timing, frame and result checks.
    task automatic run_cmd(input bit rd, input bit both, input int thr, input int phy, input int ra,
                           input logic [15:0] wd, input logic [15:0] resp, input logic [15:0] low_exp);
        int teff;
        time t0;
        logic [31:0] cw, v;
        logic [63:0] ef, mask;
        teff = (thr == 0) ? 1 : thr;
        if (!rd) host_write(1'b1, {16'h0, wd});
        resp_q = resp; rise_cnt = 0; cap_o = '0; cap_oe = '0;
        cw = ctrl_word(rd, !rd || both, ra, phy, thr);
        host_write(1'b0, cw);
        t0 = t_wr;
        host_read(1'b0, v);
        chk(v[27:26] == (rd ? 2'b01 : 2'b10), "R9 request bit stored", 64'(v[27:26]), rd ? 64'd1 : 64'd2);
        wait_to(t0 + 128*teff*20 - 10);
        host_read(1'b0, v);
        chk(v[27:26] != 2'b00, "R3 busy in last cycle", 64'(v), 64'(cw));
        @(negedge clk);
        host_read(1'b0, v);
        chk(v == (cw & 32'hF3FF_FFFF), "R2 fields kept, request cleared", 64'(v), 64'(cw & 32'hF3FF_FFFF));
        chk(t_first - t0 == 20*teff, "R3 first mdc rise", 64'(t_first - t0), 64'(20*teff));
        chk(t_second - t_first == 40*teff, "R3 mdc period", 64'(t_second - t_first), 64'(40*teff));
        chk(rise_cnt == 64, "R4 rise count", 64'(rise_cnt), 64'd64);
        ef = exp_frame(rd, phy, ra, wd);
        mask = rd ? {{46{1'b1}}, 18'b0} : '1;
        chk((cap_o & mask) == (ef & mask), "R4 frame bits", cap_o & mask, ef & mask);
        chk(cap_oe == mask, rd ? "R6 line release" : "R5 line driven", cap_oe, mask);
        if (rd) begin
            host_read(1'b1, v);
            chk(v[31:16] == (phy_on ? resp : 16'hFFFF), phy_on ? "R6 read result" : "R7 no PHY read",
                64'(v[31:16]), phy_on ? 64'(resp) : 64'hFFFF);
            chk(v[15:0] == low_exp, "R10 low half kept on read", 64'(v[15:0]), 64'(low_exp));
        end
    endtask

    initial begin
        #(150000*20);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [31:0] v, cw;
        time t0;
        logic [15:0] wd_last;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        host_read(1'b0, v); chk(v == 32'h0, "R1 command word", 64'(v), 64'h0);
        host_read(1'b1, v); chk(v == 32'h0, "R1 data word", 64'(v), 64'h0);
        chk(mdc == 1'b0, "R1 mdc low", 64'(mdc), 64'h0);
        chk(mdio_oe == 1'b0, "R1 line released", 64'(mdio_oe), 64'h0);

        // Divider sweep with write frames (R2 R3 R4 R5).
        for (int i = 0; i < 9; i++) begin
            int thr;
            thr = (i < 8) ? i : 63;
            run_cmd(1'b0, 1'b0, thr, i, i + 3, 16'hF00D ^ 16'(i), 16'h0, 16'h0);
        end
        wd_last = 16'hF00D ^ 16'd8;

        // Address sweep at divider 1: write then read per PHY address (R4 R5 R6 R10).
        for (int a = 0; a < 32; a++) begin
            logic [15:0] wd, rs;
            wd = 16'(a * 16'h0801) ^ 16'h5A3C;
            rs = 16'(a * 16'h1111) ^ 16'hC3A5;
            run_cmd(1'b0, 1'b0, 1, a, 31 - a, wd, 16'h0, 16'h0);
            run_cmd(1'b1, 1'b0, 1, a, a, 16'h0, rs, wd);
            wd_last = wd;
        end

        // R7: nobody answers
        phy_on = 1'b0;
        run_cmd(1'b1, 1'b0, 3, 17, 2, 16'h0, 16'h1234, wd_last);
        phy_on = 1'b1;

        // R9: both request bits set behaves as a read
        run_cmd(1'b1, 1'b1, 2, 9, 30, 16'h0, 16'h8001, wd_last);

        // R10: data word upper half is not host-writable
        host_write(1'b1, 32'hFFFF_1234);
        host_read(1'b1, v);
        chk(v == 32'h8001_1234, "R10 host data write", 64'(v), 64'h8001_1234);

        // R8 and R5: writes during a frame
        host_write(1'b1, 32'h0000_A5A5);
        rise_cnt = 0; cap_o = '0; cap_oe = '0;
        cw = ctrl_word(1'b0, 1'b1, 9, 5, 2);
        host_write(1'b0, cw);
        t0 = t_wr;
        repeat (40) @(negedge clk);
        host_write(1'b0, ctrl_word(1'b1, 1'b0, 1, 1, 7));
        host_write(1'b1, 32'h0000_1234);
        host_read(1'b0, v);
        chk(v == cw, "R8 busy command write ignored", 64'(v), 64'(cw));
        wait_to(t0 + 128*2*20 - 10);
        host_read(1'b0, v);
        chk(v[27] == 1'b1, "R8 original timing kept", 64'(v), 64'(cw));
        @(negedge clk);
        host_read(1'b0, v);
        chk(v == (cw & 32'hF3FF_FFFF), "R8 fields after frame", 64'(v), 64'(cw & 32'hF3FF_FFFF));
        chk(cap_o == exp_frame(1'b0, 5, 9, 16'hA5A5), "R5 data sampled at start", cap_o, exp_frame(1'b0, 5, 9, 16'hA5A5));
        host_read(1'b1, v);
        chk(v == 32'h8001_1234, "R10 mid-frame data write", 64'(v), 64'h8001_1234);
        repeat (300) @(negedge clk);
        chk(rise_cnt == 64 && mdc == 1'b0, "R8 no second frame", 64'(rise_cnt), 64'd64);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule